// File: doc/BRIEF.md
# Command-Triggered Serial Flash Read Engine

This block runs one read transaction against an external serial flash each time software writes a sequence identifier. Software first writes a flash address and a byte count into configuration registers. A later write of the sequence identifier then starts the transfer. The block gives the address, the byte count and the identifier to a flash sequencer, and it sends a one-cycle start pulse with them. After that the sequencer returns bytes over a valid/ready byte stream.

Each byte that the engine accepts goes into a 32-bit word, with the lowest byte lane filled first. A word is pushed into a 16-entry receive FIFO when it is full or when the transfer's last byte arrives. Two status flags, command-access and busy, stay high for the whole transfer. A sticky error flag records any trigger written while a transfer is still running. The current FIFO fill level can be read at any time. When the last requested byte has been accepted, the engine stops taking bytes and raises a done pulse. That pulse also tells the sequencer to stop.

Top module: `flash_cmd_reader`

## Requirements
- R1: While reset is held and after it is released, busy, command-access, error, done and start are 0, sb_ready is 0 and rx_level is 0.
- R2: A trigger write (trig_wr=1 for one cycle) when idle with a nonzero configured length makes busy and command-access 1 from the next cycle. In that same cycle seq_start pulses for one cycle, and seq_addr, seq_len and seq_id show the configured address, the configured length and the written identifier.
- R3: sb_ready is 1 only while busy and the FIFO is not full. A byte moves only on a cycle where both sb_valid and sb_ready are 1.
- R4: Transfer byte i is placed in bits [8*(i%4)+7 : 8*(i%4)] of FIFO word i/4. A final partial word has zeros in its unused upper lanes.
- R5: In the cycle after the last requested byte is accepted, busy, command-access and sb_ready are 0 and xfer_done is 1. xfer_done falls again one cycle later.
- R6: A trigger written while busy does not restart or change the running transfer. It sets stat_err, which stays 1 until reset.
- R7: rx_level equals the words pushed minus the words popped. A pop while the FIFO is empty has no effect. A push and a pop in the same cycle leave rx_level unchanged.
- R8: A trigger with a configured length of 0 gives xfer_done in the next cycle. busy stays 0, no start pulse is sent and no word is pushed.
- R9: When rx_level reaches 16, sb_ready goes low. Acceptance resumes only after a pop frees an entry, and no word is lost.
- R10: While rx_level is nonzero, rx_data shows the oldest stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the address and length configuration |
| cfg_addr | input | 24 | Flash start address to load |
| cfg_len | input | 16 | Byte count to load |
| trig_wr | input | 1 | Write of the sequence identifier; starts a transfer |
| trig_seq | input | 4 | Sequence identifier value |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_addr | output | 24 | Latched start address |
| seq_len | output | 16 | Latched byte count |
| seq_id | output | 4 | Latched sequence identifier |
| sb_valid | input | 1 | Returned byte is valid |
| sb_data | input | 8 | Returned byte |
| sb_ready | output | 1 | Engine accepts a byte this cycle |
| stat_cmd_acc | output | 1 | Command-access status flag |
| stat_busy | output | 1 | Busy status flag |
| stat_err | output | 1 | Sticky trigger-while-busy flag |
| xfer_done | output | 1 | Completion and stop pulse |
| rx_pop | input | 1 | Pop the oldest FIFO word |
| rx_data | output | 32 | Oldest FIFO word |
| rx_level | output | 5 | Number of words in the FIFO |

## Verification
The bench runs every length from 1 to 20 plus 64. This covers each partial-word remainder, so a packer that leaves stale upper bytes in place, or that skips the push on a short last word, returns a wrong word or a wrong level. The stop point is checked on the exact cycle after the last byte. A counter that is off by one therefore either takes an extra byte or stops one byte early.

A 70-byte run fills the FIFO. An engine that kept accepting bytes while full would overwrite a word and return the wrong sequence. Pushes paired with pops in the same cycle expose a level counter that counts both events on its own. A second trigger in the middle of a transfer must neither restart the count nor change the latched identifier. A zero-length trigger must not raise busy.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int SEQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              trig_wr,
  input  logic [SEQ_W-1:0]  trig_seq,
  input  logic              accept,
  output logic              last_byte,
  output logic              busy,
  output logic              err,
  output logic              done,
  output logic              start,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [SEQ_W-1:0]  seq_o
);
  rd_state_e         state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] cfa_q, cfa_d, addr_q, addr_d;
  logic [LEN_W-1:0]  cfl_q, cfl_d, len_q, len_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic              err_q, err_d, done_q, done_d, start_q, start_d;

  assign last_byte = accept && (rem_q == LEN_W'(1));

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    cfa_d   = cfa_q;
    cfl_d   = cfl_q;
    addr_d  = addr_q;
    len_d   = len_q;
    seq_d   = seq_q;
    err_d   = err_q | (trig_wr && state_q == RD_RUN);
    done_d  = 1'b0;
    start_d = 1'b0;
    if (cfg_wr) begin
      cfa_d = cfg_addr;
      cfl_d = cfg_len;
    end
    case (state_q)
      RD_IDLE: begin
        if (trig_wr) begin
          addr_d = cfa_q;
          len_d  = cfl_q;
          seq_d  = trig_seq;
          if (cfl_q == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = RD_RUN;
            rem_d   = cfl_q;
            start_d = 1'b1;
          end
        end
      end
      default: begin
        if (accept) begin
          rem_d = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) begin
            state_d = RD_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      rem_q   <= '0;
      cfa_q   <= '0;
      cfl_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      seq_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      cfa_q   <= cfa_d;
      cfl_q   <= cfl_d;
      addr_q  <= addr_d;
      len_q   <= len_d;
      seq_q   <= seq_d;
      err_q   <= err_d;
      done_q  <= done_d;
      start_q <= start_d;
    end
  end

  assign busy   = (state_q == RD_RUN);
  assign err    = err_q;
  assign done   = done_q;
  assign start  = start_q;
  assign addr_o = addr_q;
  assign len_o  = len_q;
  assign seq_o  = seq_q;

  AST_FINAL_BYTE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> (done && !busy)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_TRIG_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && busy) |=> (err && $stable(seq_o))); // R6
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
endmodule

// File: rtl/flash_byte_packer.sv
module flash_byte_packer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              last_byte,
  input  logic [7:0]        byte_i,
  output logic              push,
  output logic [DATA_W-1:0] word_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [DATA_W-1:0] acc_q, acc_d, merged;

  always_comb begin
    merged = acc_q;
    for (int k = 0; k < LANES; k++) begin
      if (lane_q == LANE_W'(k)) merged[8*k +: 8] = byte_i;
    end
  end

  assign push   = accept && (last_byte || lane_q == LANE_W'(LANES - 1));
  assign word_o = merged;

  always_comb begin
    lane_d = lane_q;
    acc_d  = acc_q;
    if (push) begin
      lane_d = '0;
      acc_d  = '0;
    end else if (accept) begin
      lane_d = lane_q + LANE_W'(1);
      acc_d  = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else begin
      lane_q <= lane_d;
      acc_q  <= acc_d;
    end
  end

  AST_LANE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_byte) |=> (lane_q == '0)); // R4
endmodule

// File: rtl/flash_rx_fifo.sv
module flash_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop,
  output logic [DATA_W-1:0]          rdata,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_en;

  assign pop_en = pop && (cnt_q != '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
    if (pop_en) rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
    if (push && !pop_en) cnt_d = cnt_q + CNT_W'(1);
    else if (!push && pop_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign level = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R9
  AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && level != '0) |=> $stable(level)); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R7
endmodule

// File: rtl/flash_cmd_reader.sv
module flash_cmd_reader #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int SEQ_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              trig_wr,
  input  logic [SEQ_W-1:0]  trig_seq,
  output logic              seq_start,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [LEN_W-1:0]  seq_len,
  output logic [SEQ_W-1:0]  seq_id,
  input  logic              sb_valid,
  input  logic [7:0]        sb_data,
  output logic              sb_ready,
  output logic              stat_cmd_acc,
  output logic              stat_busy,
  output logic              stat_err,
  output logic              xfer_done,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic [LVL_W-1:0]  rx_level
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              busy, accept, last_byte, push, full;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sb_ready = busy && !full;
  assign accept   = sb_valid && sb_ready;

  flash_rd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .trig_wr(trig_wr), .trig_seq(trig_seq),
    .accept(accept), .last_byte(last_byte), .busy(busy), .err(stat_err),
    .done(xfer_done), .start(seq_start), .addr_o(seq_addr), .len_o(seq_len),
    .seq_o(seq_id)
  );

  flash_byte_packer #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_int_n), .accept(accept), .last_byte(last_byte),
    .byte_i(sb_data), .push(push), .word_o(word)
  );

  flash_rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_int_n), .push(push), .wdata(word), .pop(rx_pop),
    .rdata(rx_data), .full(full), .level(rx_level)
  );

  assign stat_busy    = busy;
  assign stat_cmd_acc = busy;

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    sb_ready |-> stat_busy); // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_level == LVL_W'(DEPTH)) |-> !sb_ready); // R9
endmodule

// File: tb/flash_cmd_reader_tb.sv
module flash_cmd_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, trig_wr, sb_valid, rx_pop;
  logic [23:0] cfg_addr;
  logic [15:0] cfg_len;
  logic [3:0]  trig_seq;
  logic [7:0]  sb_data;
  logic        seq_start, sb_ready, stat_cmd_acc, stat_busy, stat_err, xfer_done;
  logic [23:0] seq_addr;
  logic [15:0] seq_len;
  logic [3:0]  seq_id;
  logic [31:0] rx_data;
  logic [4:0]  rx_level;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_reader u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .trig_wr(trig_wr), .trig_seq(trig_seq),
    .seq_start(seq_start), .seq_addr(seq_addr), .seq_len(seq_len),
    .seq_id(seq_id), .sb_valid(sb_valid), .sb_data(sb_data),
    .sb_ready(sb_ready), .stat_cmd_acc(stat_cmd_acc), .stat_busy(stat_busy),
    .stat_err(stat_err), .xfer_done(xfer_done), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_level(rx_level)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int i, input int len);
    return 8'((i * 37 + len * 5 + 3) & 255);
  endfunction

  function automatic logic [31:0] wexp(input int k, input int len);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < len) w[8*j +: 8] = bval(4 * k + j, len);
    return w;
  endfunction

  // pops one word at the current negedge, comparing it with word k
  task automatic pop_one(input int k, input int len);
    chk("R4/R10 word", rx_data, wexp(k, len));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic run(input int len, input logic [23:0] addr, input logic [3:0] id,
                     input bit pop_on_push, input bit trig_mid);
    int i = 0;
    int popped = 0;
    int pushed = 0;
    int lvl;
    cfg_wr = 1'b1; cfg_addr = addr; cfg_len = 16'(len);
    @(negedge clk);
    cfg_wr = 1'b0;
    trig_wr = 1'b1; trig_seq = id;
    @(negedge clk);
    trig_wr = 1'b0;
    chk("R2 busy", stat_busy, 1);
    chk("R2 cmd_acc", stat_cmd_acc, 1);
    chk("R2 start", seq_start, 1);
    chk("R2 addr", seq_addr, addr);
    chk("R2 len", seq_len, len);
    chk("R2 id", seq_id, id);
    while (i < len) begin
      sb_valid = 1'b1;
      sb_data  = bval(i, len);
      if (trig_mid && i == 2) begin
        trig_wr = 1'b1; trig_seq = ~id;
        cfg_wr = 1'b1; cfg_len = 16'd3;
      end
      if (sb_ready) begin
        lvl = rx_level;
        if (pop_on_push && lvl > 0 && ((i % 4) == 3 || i == len - 1)) begin
          chk("R10 head", rx_data, wexp(popped, len));
          rx_pop = 1'b1;
          @(negedge clk);
          rx_pop = 1'b0;
          popped++; pushed++;
          chk("R7 push+pop level", rx_level, lvl);
        end else begin
          @(negedge clk);
          if ((i % 4) == 3 || i == len - 1) pushed++;
        end
        i++;
        if (trig_mid && i == 3) begin
          trig_wr = 1'b0; cfg_wr = 1'b0;
          chk("R6 err set", stat_err, 1);
          chk("R6 id kept", seq_id, id);
          chk("R6 no restart", seq_start, 0);
        end
      end else begin
        chk("R9 full level", rx_level, 16);
        chk("R3 ready low when full", sb_ready, 0);
        pop_one(popped, len);
        popped++;
      end
    end
    sb_valid = 1'b0;
    chk("R5 done", xfer_done, 1);
    chk("R5 busy clear", stat_busy, 0);
    chk("R5 cmd_acc clear", stat_cmd_acc, 0);
    chk("R5 ready low", sb_ready, 0);
    chk("R7 level", rx_level, pushed - popped);
    @(negedge clk);
    chk("R5 done pulse ends", xfer_done, 0);
    while (popped < (len + 3) / 4) begin
      pop_one(popped, len);
      popped++;
    end
    chk("R7 drained", rx_level, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wr = 0; trig_wr = 0; sb_valid = 0; rx_pop = 0;
    cfg_addr = '0; cfg_len = '0; trig_seq = '0; sb_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", stat_busy, 0);
    chk("R1 level in reset", rx_level, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", stat_busy, 0);
    chk("R1 cmd_acc", stat_cmd_acc, 0);
    chk("R1 err", stat_err, 0);
    chk("R1 done", xfer_done, 0);
    chk("R1 start", seq_start, 0);
    chk("R1 ready", sb_ready, 0);
    chk("R1 level", rx_level, 0);

    // R7: pop while empty ignored
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    chk("R7 empty pop", rx_level, 0);

    // R3: byte offered while idle is not taken
    sb_valid = 1'b1; sb_data = 8'hAA;
    @(negedge clk);
    chk("R3 idle ready", sb_ready, 0);
    chk("R3 idle level", rx_level, 0);
    sb_valid = 1'b0;

    // R8: zero-length trigger
    cfg_wr = 1'b1; cfg_len = 16'd0; cfg_addr = 24'h123456;
    @(negedge clk);
    cfg_wr = 1'b0; trig_wr = 1'b1; trig_seq = 4'h5;
    @(negedge clk);
    trig_wr = 1'b0;
    chk("R8 done", xfer_done, 1);
    chk("R8 busy", stat_busy, 0);
    chk("R8 start", seq_start, 0);
    chk("R8 level", rx_level, 0);
    @(negedge clk);
    chk("R8 done ends", xfer_done, 0);

    // R4/R5: sweep of lengths covering every remainder
    for (int len = 1; len <= 20; len++)
      run(len, 24'(len * 4099), 4'(len), 1'b0, 1'b0);
    run(64, 24'hABCDE0, 4'hC, 1'b0, 1'b0);

    // R7: pushes paired with pops
    run(13, 24'h000100, 4'h3, 1'b1, 1'b0);
    run(8, 24'h000200, 4'h4, 1'b1, 1'b0);

    // R9: FIFO fills and stalls the stream
    run(70, 24'h0F0000, 4'h9, 1'b0, 1'b0);

    // R6: trigger while busy
    run(11, 24'h777000, 4'h6, 1'b0, 1'b1);
    chk("R6 err sticky", stat_err, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule